// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatch Unit

This block sits inside a local interrupt controller and turns one write of an interrupt command word into interrupt messages for other processors. The command carries a vector, a delivery mode, a trigger mode, an explicit destination ID and a two-bit target selector. Depending on the selector, the block sends a single message to a named processor, raises a request on its own processor only, or fans out one message to every other processor. Every processor ID in the system is below a configured count.

Messages leave through a valid/ready request port, one per accepted transfer. The block counts the messages that still wait for a response and keeps a busy flag (delivery status) set until the last response has come back. While the flag is set, further commands are refused and flagged. A response that arrives when nothing is outstanding is dropped and flagged.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, `busy`, `msg_valid`, `loc_req`, `wr_err` and `rsp_err` are all 0.
- R2: A command with `cmd_short` = 0 (explicit target) produces exactly one message, with `msg_dest` equal to `cmd_dest`. This holds even when `cmd_dest` equals the local ID. The message carries the command's vector, mode and trigger.
- R3: A command with `cmd_short` = 1 (self only) sends no message and leaves `busy` at 0. It raises `loc_req` for exactly one cycle, starting the cycle after the write, with `loc_vector`, `loc_mode` and `loc_trig` taken from the command.
- R4: A command with `cmd_short` = 2 (everyone including self) raises the one-cycle `loc_req` of R3 and also sends the broadcast messages of R5.
- R5: A command with `cmd_short` = 3 (everyone except self) sends one message to each ID from 0 to `NUM_CPUS`-1 other than `LOCAL_ID`, in ascending order, and never addresses `LOCAL_ID`.
- R6: A message is transferred on a cycle where both `msg_valid` and `msg_ready` are 1. While `msg_ready` is 0, `msg_valid` and `msg_dest` hold their values.
- R7: A command that sends messages sets `busy` from the cycle after the write. The outstanding count becomes 1 for selector 0 and `NUM_CPUS`-1 for selectors 2 and 3. Each `rsp_valid` pulse lowers the count by one. `busy` clears only after the response that brings the count to zero.
- R8: A command written while `busy` is 1 has no effect: no message is sent, no `loc_req` is raised, and no field changes. `wr_err` pulses for one cycle after such a write.
- R9: A response that arrives when the outstanding count is zero is ignored, so the count does not wrap. `rsp_err` pulses for one cycle and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_vector | input | 8 | Interrupt vector |
| cmd_mode | input | 3 | Delivery mode |
| cmd_trig | input | 1 | Trigger mode |
| cmd_short | input | 2 | Target selector: 0 explicit, 1 self, 2 all, 3 all but self |
| cmd_dest | input | 4 | Explicit destination ID |
| busy | output | 1 | Delivery status; set while any response is outstanding |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_dest | output | 4 | Target processor ID of the message |
| msg_vector | output | 8 | Vector of the message |
| msg_mode | output | 3 | Delivery mode of the message |
| msg_trig | output | 1 | Trigger mode of the message |
| rsp_valid | input | 1 | One message response returned |
| rsp_err | output | 1 | One-cycle pulse after a response with nothing outstanding |
| loc_req | output | 1 | One-cycle local interrupt request |
| loc_vector | output | 8 | Vector of the local request |
| loc_mode | output | 3 | Delivery mode of the local request |
| loc_trig | output | 1 | Trigger mode of the local request |

## Verification
The hardest case to reach is the middle of a broadcast. At that point, messages are stalled by a low `msg_ready`, the local ID must be skipped in the middle of the ID range, and the busy flag must survive every response except the last. The stimulus drives the ready line low on every third cycle while messages are collected, so stalls occur both before and after the skipped ID. Responses are then returned one at a time, and the busy flag is checked after each one. Refused writes and stray responses are placed while a command is in flight or fully idle, and the following command is checked to confirm that the count was not disturbed.

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int NUM_CPUS = 5,
  parameter int LOCAL_ID = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_vector,
  input  logic [2:0] cmd_mode,
  input  logic       cmd_trig,
  input  logic [1:0] cmd_short,
  input  logic [3:0] cmd_dest,
  output logic       busy,
  output logic       wr_err,
  output logic       msg_valid,
  input  logic       msg_ready,
  output logic [3:0] msg_dest,
  output logic [7:0] msg_vector,
  output logic [2:0] msg_mode,
  output logic       msg_trig,
  input  logic       rsp_valid,
  output logic       rsp_err,
  output logic       loc_req,
  output logic [7:0] loc_vector,
  output logic [2:0] loc_mode,
  output logic       loc_trig
);
  localparam int CNT_W = $clog2(NUM_CPUS) + 1;
  localparam logic [4:0] LOC5 = 5'(LOCAL_ID);
  localparam logic [4:0] N5 = 5'(NUM_CPUS);
  localparam logic [3:0] FIRST = (LOCAL_ID == 0) ? 4'd1 : 4'd0;
  localparam logic [CNT_W-1:0] BCAST_CNT = CNT_W'(NUM_CPUS - 1);

  logic             bcast;
  logic [3:0]       cur;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       vec_q;
  logic [2:0]       mode_q;
  logic             trig_q;

  wire accept = cmd_wr && !busy;
  wire sends  = accept && (cmd_short != 2'd1);
  wire xfer   = msg_valid && msg_ready;

  wire [4:0] step1 = {1'b0, cur} + 5'd1;
  wire [4:0] step  = (step1 == LOC5) ? step1 + 5'd1 : step1;
  wire       done  = !bcast || (step >= N5);

  assign msg_dest   = cur;
  assign msg_vector = vec_q;
  assign msg_mode   = mode_q;
  assign msg_trig   = trig_q;
  assign loc_vector = vec_q;
  assign loc_mode   = mode_q;
  assign loc_trig   = trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      msg_valid <= 1'b0;
      bcast     <= 1'b0;
      cur       <= '0;
      cnt       <= '0;
      vec_q     <= '0;
      mode_q    <= '0;
      trig_q    <= 1'b0;
      loc_req   <= 1'b0;
      wr_err    <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      loc_req <= accept && (cmd_short == 2'd1 || cmd_short == 2'd2);
      wr_err  <= cmd_wr && busy;
      rsp_err <= rsp_valid && (cnt == '0);
      if (accept) begin
        vec_q  <= cmd_vector;
        mode_q <= cmd_mode;
        trig_q <= cmd_trig;
      end
      if (sends) begin
        busy      <= 1'b1;
        msg_valid <= 1'b1;
        bcast     <= cmd_short[1];
        cur       <= cmd_short[1] ? FIRST : cmd_dest;
        cnt       <= cmd_short[1] ? BCAST_CNT : CNT_W'(1);
      end else begin
        if (xfer) begin
          if (done) msg_valid <= 1'b0;
          else      cur <= step[3:0];
        end
        if (rsp_valid && cnt != '0) begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) busy <= 1'b0;
        end
      end
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) $past(!rst_n) |-> !busy && !msg_valid && !loc_req);
  // R3
  loc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) loc_req |=> !loc_req);
  // R5
  skip_self_chk: assert property (@(posedge clk) disable iff (!rst_n) msg_valid && bcast |-> msg_dest != LOCAL_ID[3:0]);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) msg_valid && !msg_ready |=> msg_valid && $stable(msg_dest));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && cnt > CNT_W'(1) |=> busy);
  // R7
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cnt == '0 && !msg_valid);
  // R8
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_wr && busy |=> !loc_req && $stable(vec_q));
  // R9
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && !busy && !cmd_wr |=> !busy);
endmodule

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;
  localparam int N = 5;
  localparam int LID = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, cmd_trig = 0, msg_ready = 0, rsp_valid = 0;
  logic [7:0] cmd_vector = 0;
  logic [2:0] cmd_mode = 0;
  logic [1:0] cmd_short = 0;
  logic [3:0] cmd_dest = 0;
  logic busy, wr_err, msg_valid, msg_trig, rsp_err, loc_req, loc_trig;
  logic [3:0] msg_dest;
  logic [7:0] msg_vector, loc_vector;
  logic [2:0] msg_mode, loc_mode;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ipi_dispatch #(.NUM_CPUS(N), .LOCAL_ID(LID)) i_ipi_dispatch (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_vector(cmd_vector),
    .cmd_mode(cmd_mode), .cmd_trig(cmd_trig), .cmd_short(cmd_short),
    .cmd_dest(cmd_dest), .busy(busy), .wr_err(wr_err), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_trig(msg_trig), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .loc_req(loc_req), .loc_vector(loc_vector),
    .loc_mode(loc_mode), .loc_trig(loc_trig));

  // {selector, dest, vector, mode, trig}
  localparam logic [17:0] TBL [0:5] = '{
    {2'd0, 4'd3, 8'h41, 3'd0, 1'b0},
    {2'd3, 4'd0, 8'h52, 3'd0, 1'b1},
    {2'd1, 4'd0, 8'h63, 3'd2, 1'b0},
    {2'd2, 4'd0, 8'h74, 3'd4, 1'b1},
    {2'd0, 4'd2, 8'h85, 3'd1, 1'b0},
    {2'd3, 4'd1, 8'hF0, 3'd5, 1'b1}};

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_cmd(logic [1:0] sh, logic [3:0] d, logic [7:0] v, logic [2:0] m, logic t);
    @(negedge clk);
    cmd_wr = 1; cmd_short = sh; cmd_dest = d; cmd_vector = v; cmd_mode = m; cmd_trig = t;
    @(negedge clk);
    cmd_wr = 0;
  endtask

  task automatic respond();
    @(negedge clk); rsp_valid = 1;
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic run_cmd(logic [17:0] e);
    logic [1:0] sh = e[17:16];
    logic [7:0] v = e[11:4];
    int exp_ids[$];
    int got = 0, held = 0;
    bit stalled = 0;
    if (sh == 2'd0) exp_ids.push_back(int'(e[15:12]));
    else if (sh != 2'd1) for (int i = 0; i < N; i++) if (i != LID) exp_ids.push_back(i);
    write_cmd(sh, e[15:12], v, e[3:1], e[0]);
    chk("R3/R4", "loc_req after write", int'(loc_req), int'(sh == 2'd1 || sh == 2'd2));
    if (loc_req) begin
      chk("R3", "loc_vector", int'(loc_vector), int'(v));
      chk("R3", "loc_mode", int'(loc_mode), int'(e[3:1]));
      chk("R3", "loc_trig", int'(loc_trig), int'(e[0]));
    end
    chk("R7", "busy after write", int'(busy), int'(sh != 2'd1));
    if (sh == 2'd1) begin
      chk("R3", "no message", int'(msg_valid), 0);
      @(negedge clk);
      chk("R3", "loc_req one cycle", int'(loc_req), 0);
      chk("R3", "busy stays clear", int'(busy), 0);
      return;
    end
    for (int k = 0; k < 200 && msg_valid; k++) begin
      if (k == 1) chk("R4", "loc_req one cycle", int'(loc_req), 0);
      if (stalled) chk("R6", "dest held in stall", int'(msg_dest), held);
      msg_ready = (k % 3 != 1);
      if (msg_ready) begin
        chk(sh == 2'd0 ? "R2" : "R5", "msg_dest", int'(msg_dest), got < exp_ids.size() ? exp_ids[got] : -1);
        chk("R2", "msg_vector", int'(msg_vector), int'(v));
        got++;
        stalled = 0;
      end else begin
        stalled = 1;
        held = int'(msg_dest);
      end
      @(negedge clk);
    end
    msg_ready = 0;
    chk(sh == 2'd0 ? "R2" : "R5", "message count", got, exp_ids.size());
    for (int i = 0; i < exp_ids.size(); i++) begin
      chk("R7", "busy before response", int'(busy), 1);
      respond();
    end
    chk("R7", "busy after last response", int'(busy), 0);
  endtask

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "msg_valid", int'(msg_valid), 0);
    chk("R1", "loc_req", int'(loc_req), 0);
    chk("R1", "errors", int'(wr_err | rsp_err), 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) run_cmd(TBL[i]);

    // R8 refused write while busy
    write_cmd(2'd0, 4'd4, 8'h11, 3'd0, 1'b0);
    write_cmd(2'd2, 4'd0, 8'h22, 3'd0, 1'b0);
    chk("R8", "wr_err pulse", int'(wr_err), 1);
    chk("R8", "no loc_req", int'(loc_req), 0);
    chk("R8", "vector unchanged", int'(msg_vector), 8'h11);
    @(negedge clk);
    chk("R8", "wr_err one cycle", int'(wr_err), 0);
    chk("R8", "dest unchanged", int'(msg_dest), 4);
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
    chk("R8", "no extra message", int'(msg_valid), 0);
    respond();
    chk("R8", "busy clear after one response", int'(busy), 0);

    // R9 stray response
    @(negedge clk); rsp_valid = 1;
    @(negedge clk); rsp_valid = 0;
    chk("R9", "rsp_err pulse", int'(rsp_err), 1);
    chk("R9", "busy stays clear", int'(busy), 0);
    @(negedge clk);
    chk("R9", "rsp_err one cycle", int'(rsp_err), 0);
    run_cmd({2'd0, 4'd1, 8'h99, 3'd0, 1'b1});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule